// File: doc/BRIEF.md
# Two-Channel Instruction Breakpoint Unit

This block sits beside a processor's instruction stream and asks the core to stop when a programmed instruction comes through. Each cycle in which `insn_vld` is high carries one instruction: its program counter, its address-space ID and a 32-bit data word. Two channels compare that instruction against their settings. Each channel has a reference address with a mask. It also has an ASID qualifier that can be switched on or off. A timing choice makes the channel stop the core either before the instruction runs or just after it has run. Channel 1 also has a masked data compare and an occurrence counter.

A mode bit links the channels. In linked mode, channel 0 does not stop the core. It only arms channel 1, and channel 1 then stops the core on its own match. The core sees `brk_req` together with the number of the channel that fired. It also sees `retire_ok`, which tells it whether the current instruction may complete. Software programs the unit through a 32-bit register port. A status bit for each channel records every break and stays set until software clears it.

Register map (word index on `reg_addr`): 0 ch0 control, 1 ch0 address, 2 ch0 address mask, 3 ch1 control, 4 ch1 address, 5 ch1 address mask, 6 ch1 data, 7 ch1 data mask, 8 ch1 count, 9 mode (bit 0 = linked), 10 status (bit n = channel n, write 1 to clear). Control bits: [0] enable, [1] break after execution, [2] ASID compare enable, [3] data compare enable (ch1), [4] counter enable (ch1), [15:8] ASID. Unmapped indices read 0.

Top module: `ibrk_unit`

## Requirements
- R1: A channel's address matches when the PC equals the reference address in every bit whose mask bit is 0. Mask bits set to 1 are excluded from the compare. A zero mask needs an exact match, and a mask of 0xFFF accepts any address in the same 4 KiB region.
- R2: With control bit 1 clear (before-execution timing), a channel that fires raises `brk_req` in the same cycle as `insn_vld`, and `retire_ok` is low for that instruction.
- R3: With control bit 1 set (after-execution timing), `retire_ok` stays high and `brk_req` is raised in the cycle after the instruction's strobe. `brk_req` is never raised without a strobe in the same or the previous cycle.
- R4: When control bit 2 is set, a channel also needs `insn_asid` to equal control bits [15:8]. When bit 2 is clear, the ASID has no effect.
- R5: When ch1 control bit 3 is set, channel 1 also needs the masked data match: register 6 against `insn_data`, ignoring the bits that are set in register 7. When bit 3 is clear, the data has no effect.
- R6: With ch1 control bit 4 set and count N written to register 8, the first N-1 matching instructions complete without a break and the Nth breaks. The count then stays at 1, so every later match breaks. Register 8 reads back the remaining count.
- R7: With mode bit 0 set, channel 0 never raises a break. A channel 1 match breaks only after a channel 0 match on an earlier instruction. With mode bit 0 clear, each channel breaks on its own.
- R8: A write to register 8 reloads the count and disarms linked mode.
- R9: A break sets the channel's status bit, which holds until a 1 is written to that bit of register 10. Setting wins over a clear in the same cycle.
- R10: When several channels raise a break in the same cycle, `brk_chan` gives the lowest-numbered of them.
- R11: After reset, all registers read 0, no break is raised and every instruction retires.
- R12: A channel whose control bit 0 is clear never raises a break.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| insn_vld | input | 1 | Instruction strobe, one per instruction |
| insn_pc | input | ADDR_W | Program counter of the instruction |
| insn_asid | input | ASID_W | Address-space ID of the instruction |
| insn_data | input | DATA_W | Data word compared by channel 1 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data (combinational) |
| retire_ok | output | 1 | Current instruction may complete |
| brk_req | output | 1 | Break request |
| brk_chan | output | 1 | Channel that raised the break |

## Verification
The bound checker checks a set of rules on every cycle:
- after-execution breaks only follow a retired instruction;
- a before-execution break always blocks retirement;
- in linked mode channel 0 stays silent;
- status bits are sticky, and every break sets them;
- a count reload leaves the link disarmed, and the count never wraps to zero on its own;
- the reported channel is the lowest one firing.

Whether a match should happen at all depends on the programmed values. The bench's scenarios therefore cover the rest: mask and ASID qualification, data masking, the fifth-occurrence count, arming order in linked mode, and the reset values.

// File: rtl/ibrk_pkg.sv
package ibrk_pkg;
  localparam int unsigned CMP_W = 32;

  typedef enum logic [3:0] {
    RG_C0_CTL  = 4'd0,
    RG_C0_ADR  = 4'd1,
    RG_C0_AMSK = 4'd2,
    RG_C1_CTL  = 4'd3,
    RG_C1_ADR  = 4'd4,
    RG_C1_AMSK = 4'd5,
    RG_C1_DAT  = 4'd6,
    RG_C1_DMSK = 4'd7,
    RG_C1_CNT  = 4'd8,
    RG_MODE    = 4'd9,
    RG_STAT    = 4'd10
  } reg_idx_e;

  localparam int CTL_EN       = 0;
  localparam int CTL_POST     = 1;
  localparam int CTL_ASID_EN  = 2;
  localparam int CTL_DATA_EN  = 3;
  localparam int CTL_CNT_EN   = 4;
  localparam int CTL_ASID_LSB = 8;

  // Bits set in m are don't-care.
  function automatic logic masked_eq(input logic [CMP_W-1:0] a,
                                     input logic [CMP_W-1:0] b,
                                     input logic [CMP_W-1:0] m);
    return ((a ^ b) & ~m) == '0;
  endfunction
endpackage

// File: rtl/ibrk_regs.sv
module ibrk_regs
  import ibrk_pkg::*;
#(
  parameter int REG_W = 32,
  parameter int CNT_W = 16,
  parameter int NCH   = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [3:0]                addr,
  input  logic [REG_W-1:0]          wdata,
  output logic [REG_W-1:0]          rdata,
  input  logic [NCH-1:0]            brk_vec,
  input  logic [CNT_W-1:0]          cnt_cur,
  output logic [NCH-1:0][REG_W-1:0] ctl_q,
  output logic [NCH-1:0][REG_W-1:0] adr_q,
  output logic [NCH-1:0][REG_W-1:0] amsk_q,
  output logic [REG_W-1:0]          dat_q,
  output logic [REG_W-1:0]          dmsk_q,
  output logic [REG_W-1:0]          mode_q,
  output logic [NCH-1:0]            stat_q,
  output logic                      cnt_load,
  output logic [CNT_W-1:0]          cnt_val
);
  logic [NCH-1:0] stat_clr;

  assign stat_clr = (we && addr == RG_STAT) ? wdata[NCH-1:0] : '0;
  assign cnt_load = we && (addr == RG_C1_CNT);
  assign cnt_val  = wdata[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      adr_q  <= '0;
      amsk_q <= '0;
      dat_q  <= '0;
      dmsk_q <= '0;
      mode_q <= '0;
      stat_q <= '0;
    end else begin
      if (we) begin
        case (reg_idx_e'(addr))
          RG_C0_CTL:  ctl_q[0]  <= wdata;
          RG_C0_ADR:  adr_q[0]  <= wdata;
          RG_C0_AMSK: amsk_q[0] <= wdata;
          RG_C1_CTL:  ctl_q[1]  <= wdata;
          RG_C1_ADR:  adr_q[1]  <= wdata;
          RG_C1_AMSK: amsk_q[1] <= wdata;
          RG_C1_DAT:  dat_q     <= wdata;
          RG_C1_DMSK: dmsk_q    <= wdata;
          RG_MODE:    mode_q    <= wdata;
          default: ;
        endcase
      end
      stat_q <= (stat_q & ~stat_clr) | brk_vec;
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_idx_e'(addr))
      RG_C0_CTL:  rdata = ctl_q[0];
      RG_C0_ADR:  rdata = adr_q[0];
      RG_C0_AMSK: rdata = amsk_q[0];
      RG_C1_CTL:  rdata = ctl_q[1];
      RG_C1_ADR:  rdata = adr_q[1];
      RG_C1_AMSK: rdata = amsk_q[1];
      RG_C1_DAT:  rdata = dat_q;
      RG_C1_DMSK: rdata = dmsk_q;
      RG_C1_CNT:  rdata = REG_W'(cnt_cur);
      RG_MODE:    rdata = mode_q;
      RG_STAT:    rdata = REG_W'(stat_q);
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/ibrk_match.sv
module ibrk_match
  import ibrk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ASID_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              en,
  input  logic              asid_en,
  input  logic              data_en,
  input  logic [ADDR_W-1:0] ref_addr,
  input  logic [ADDR_W-1:0] addr_msk,
  input  logic [ASID_W-1:0] ref_asid,
  input  logic [DATA_W-1:0] ref_data,
  input  logic [DATA_W-1:0] data_msk,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ASID_W-1:0] asid,
  input  logic [DATA_W-1:0] data,
  output logic              hit
);
  logic addr_ok, asid_ok, data_ok;

  assign addr_ok = masked_eq(CMP_W'(pc), CMP_W'(ref_addr), CMP_W'(addr_msk));
  assign asid_ok = !asid_en || (asid == ref_asid);
  assign data_ok = !data_en || masked_eq(CMP_W'(data), CMP_W'(ref_data), CMP_W'(data_msk));
  assign hit     = en && addr_ok && asid_ok && data_ok;
endmodule

// File: rtl/ibrk_seqcnt.sv
module ibrk_seqcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seq_mode,
  input  logic             hit0,
  input  logic             hit1,
  input  logic             cnt_en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             fire0,
  output logic             fire1,
  output logic             armed,
  output logic [CNT_W-1:0] cnt
);
  logic ch1_ok, at_last;

  assign ch1_ok  = hit1 && (!seq_mode || armed);
  assign at_last = (cnt <= CNT_W'(1));
  assign fire0   = hit0 && !seq_mode;
  assign fire1   = ch1_ok && (!cnt_en || at_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (load) begin
      cnt   <= load_val;
      armed <= 1'b0;
    end else begin
      if (ch1_ok && cnt_en && !at_last) cnt <= cnt - CNT_W'(1);
      if (seq_mode && hit0) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/ibrk_unit.sv
module ibrk_unit
  import ibrk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ASID_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_vld,
  input  logic [ADDR_W-1:0] insn_pc,
  input  logic [ASID_W-1:0] insn_asid,
  input  logic [DATA_W-1:0] insn_data,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              retire_ok,
  output logic              brk_req,
  output logic              brk_chan
);
  localparam int NCH = 2;
  localparam int CHW = 1;

  logic [NCH-1:0][REG_W-1:0] ctl_q, adr_q, amsk_q;
  logic [REG_W-1:0]          dat_q, dmsk_q, mode_q;
  logic [NCH-1:0]            stat_q, hit_vec, fire_vec, post_sel, pre_vec, post_q, brk_vec;
  logic                      cnt_load, seq_mode, armed;
  logic [CNT_W-1:0]          cnt_val, cnt;

  ibrk_regs #(.REG_W(REG_W), .CNT_W(CNT_W), .NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .brk_vec(brk_vec), .cnt_cur(cnt),
    .ctl_q(ctl_q), .adr_q(adr_q), .amsk_q(amsk_q), .dat_q(dat_q), .dmsk_q(dmsk_q),
    .mode_q(mode_q), .stat_q(stat_q), .cnt_load(cnt_load), .cnt_val(cnt_val)
  );

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    logic m_hit;
    ibrk_match #(.ADDR_W(ADDR_W), .ASID_W(ASID_W), .DATA_W(DATA_W)) u_match (
      .en       (ctl_q[gi][CTL_EN]),
      .asid_en  (ctl_q[gi][CTL_ASID_EN]),
      .data_en  ((gi == 1) ? ctl_q[gi][CTL_DATA_EN] : 1'b0),
      .ref_addr (adr_q[gi][ADDR_W-1:0]),
      .addr_msk (amsk_q[gi][ADDR_W-1:0]),
      .ref_asid (ctl_q[gi][CTL_ASID_LSB +: ASID_W]),
      .ref_data (dat_q[DATA_W-1:0]),
      .data_msk (dmsk_q[DATA_W-1:0]),
      .pc       (insn_pc),
      .asid     (insn_asid),
      .data     (insn_data),
      .hit      (m_hit)
    );
    assign hit_vec[gi]  = insn_vld && m_hit;
    assign post_sel[gi] = ctl_q[gi][CTL_POST];
  end

  assign seq_mode = mode_q[0];

  ibrk_seqcnt #(.CNT_W(CNT_W)) u_seqcnt (
    .clk(clk), .rst_n(rst_n), .seq_mode(seq_mode),
    .hit0(hit_vec[0]), .hit1(hit_vec[1]), .cnt_en(ctl_q[1][CTL_CNT_EN]),
    .load(cnt_load), .load_val(cnt_val),
    .fire0(fire_vec[0]), .fire1(fire_vec[1]), .armed(armed), .cnt(cnt)
  );

  assign pre_vec   = fire_vec & ~post_sel;
  assign retire_ok = insn_vld && (pre_vec == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) post_q <= '0;
    else        post_q <= fire_vec & post_sel & {NCH{retire_ok}};
  end

  assign brk_vec = pre_vec | post_q;
  assign brk_req = |brk_vec;

  always_comb begin
    brk_chan = 1'b0;
    for (int i = NCH - 1; i >= 0; i--)
      if (brk_vec[i]) brk_chan = CHW'(i);
  end
endmodule

// File: rtl/ibrk_unit_chk.sv
module ibrk_unit_chk
  import ibrk_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int CNT_W = 16,
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             insn_vld,
  input logic             retire_ok,
  input logic             brk_req,
  input logic             brk_chan,
  input logic             reg_we,
  input logic [3:0]       reg_addr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [NCH-1:0]   post_q,
  input logic [NCH-1:0]   brk_vec,
  input logic [NCH-1:0]   stat_q,
  input logic             seq_mode,
  input logic             armed,
  input logic [CNT_W-1:0] cnt
);
  logic [NCH-1:0] clr_req;
  logic           load_req;

  assign clr_req  = (reg_we && reg_addr == RG_STAT) ? reg_wdata[NCH-1:0] : '0;
  assign load_req = reg_we && (reg_addr == RG_C1_CNT);

  AST_POST_AFTER_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (|post_q) |-> $past(retire_ok)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!insn_vld && !$past(insn_vld)) |-> !brk_req); // R3
  AST_PRE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && post_q == '0) |-> (insn_vld && !retire_ok)); // R2
  AST_SEQ_CH0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_mode && $past(seq_mode)) |-> !brk_vec[0]); // R7
  AST_STICKY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    ((~stat_q & $past(stat_q) & ~$past(clr_req)) == '0)); // R9
  AST_BREAK_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (|brk_vec) |=> ((stat_q & $past(brk_vec)) == $past(brk_vec))); // R9
  AST_LOAD_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> !armed); // R8
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) != '0 && !$past(load_req)) |-> (cnt != '0)); // R6
  AST_LOWEST_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (brk_vec[brk_chan] && (brk_chan == 1'b0 || !brk_vec[0]))); // R10
endmodule

bind ibrk_unit ibrk_unit_chk #(.NCH(NCH), .CNT_W(CNT_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .insn_vld(insn_vld), .retire_ok(retire_ok),
  .brk_req(brk_req), .brk_chan(brk_chan), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .post_q(post_q), .brk_vec(brk_vec), .stat_q(stat_q),
  .seq_mode(seq_mode), .armed(armed), .cnt(cnt)
);

// File: tb/ibrk_unit_tb.sv
`timescale 1ns/1ps
module ibrk_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_vld = 1'b0;
  logic [31:0] insn_pc = '0;
  logic [7:0]  insn_asid = '0;
  logic [31:0] insn_data = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        retire_ok, brk_req, brk_chan;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ibrk_unit u_dut (
    .clk(clk), .rst_n(rst_n), .insn_vld(insn_vld), .insn_pc(insn_pc),
    .insn_asid(insn_asid), .insn_data(insn_data), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .retire_ok(retire_ok), .brk_req(brk_req), .brk_chan(brk_chan)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // Issue one instruction, then one idle cycle.
  // Result: {pre_req, pre_chan, retire, post_req, post_chan}
  task automatic issue(input logic [31:0] pc, input logic [7:0] asid,
                       input logic [31:0] data, output logic [4:0] r);
    @(negedge clk);
    insn_vld = 1'b1; insn_pc = pc; insn_asid = asid; insn_data = data;
    #1 r[4:2] = {brk_req, brk_chan, retire_ok};
    @(negedge clk);
    insn_vld = 1'b0;
    #1 r[1:0] = {brk_req, brk_chan};
  endtask

  task automatic quiesce();
    wr(4'd0, 0); wr(4'd3, 0); wr(4'd2, 0); wr(4'd5, 0);
    wr(4'd7, 0); wr(4'd9, 0); wr(4'd10, 32'h3);
  endtask

  localparam logic [4:0] NONE = 5'b00100;
  localparam logic [4:0] PRE0 = 5'b10000;
  localparam logic [4:0] PRE1 = 5'b11000;
  localparam logic [4:0] POST0 = 5'b00110;

  task automatic t_reset();
    logic [31:0] d;
    logic [4:0]  r;
    for (int i = 0; i < 11; i++) begin
      rd(4'(i), d);
      chk($sformatf("R11 reg %0d after reset", i), d, 32'h0);
    end
    issue(32'h0, 8'h0, 32'h0, r);
    chk("R11 no break after reset", 32'(r), 32'(NONE));
  endtask

  task automatic t_addr();
    logic [4:0] r;
    quiesce();
    wr(4'd1, 32'h500); wr(4'd0, 32'h1);
    issue(32'h500, 8'h0, 0, r); chk("R1 R2 exact match pre-exec", 32'(r), 32'(PRE0));
    issue(32'h504, 8'h0, 0, r); chk("R1 exact mask rejects neighbour", 32'(r), 32'(NONE));
    wr(4'd1, 32'h8404); wr(4'd2, 32'hFFF);
    issue(32'h8ABC, 8'h0, 0, r); chk("R1 4KiB mask accepts region", 32'(r), 32'(PRE0));
    issue(32'h9404, 8'h0, 0, r); chk("R1 4KiB mask rejects next region", 32'(r), 32'(NONE));
    wr(4'd0, 32'h0);
    issue(32'h8404, 8'h0, 0, r); chk("R12 disabled channel silent", 32'(r), 32'(NONE));
  endtask

  task automatic t_post();
    logic [4:0] r;
    quiesce();
    wr(4'd1, 32'h600); wr(4'd0, 32'h3);
    issue(32'h600, 8'h0, 0, r); chk("R3 post-exec break next cycle", 32'(r), 32'(POST0));
  endtask

  task automatic t_asid();
    logic [4:0] r;
    quiesce();
    wr(4'd1, 32'h700); wr(4'd0, 32'h8005);
    issue(32'h700, 8'h70, 0, r); chk("R4 ASID mismatch blocks", 32'(r), 32'(NONE));
    issue(32'h700, 8'h80, 0, r); chk("R4 ASID match breaks", 32'(r), 32'(PRE0));
    wr(4'd0, 32'h8001);
    issue(32'h700, 8'h70, 0, r); chk("R4 ASID ignored when off", 32'(r), 32'(PRE0));
  endtask

  task automatic t_data();
    logic [4:0] r;
    quiesce();
    wr(4'd4, 32'h300); wr(4'd6, 32'h1234); wr(4'd7, 32'hFF); wr(4'd3, 32'h9);
    issue(32'h300, 8'h0, 32'h12AA, r); chk("R5 masked data match", 32'(r), 32'(PRE1));
    issue(32'h300, 8'h0, 32'h1334, r); chk("R5 data mismatch blocks", 32'(r), 32'(NONE));
    wr(4'd3, 32'h1);
    issue(32'h300, 8'h0, 32'h1334, r); chk("R5 data ignored when off", 32'(r), 32'(PRE1));
  endtask

  task automatic t_count();
    logic [4:0]  r;
    logic [31:0] d;
    quiesce();
    wr(4'd4, 32'h1000); wr(4'd3, 32'h11); wr(4'd8, 32'd5);
    for (int i = 1; i <= 4; i++) begin
      issue(32'h1000, 8'h0, 0, r);
      chk($sformatf("R6 occurrence %0d retires", i), 32'(r), 32'(NONE));
    end
    issue(32'h1000, 8'h0, 0, r); chk("R6 fifth occurrence breaks", 32'(r), 32'(PRE1));
    rd(4'd8, d); chk("R6 remaining count", d, 32'd1);
    issue(32'h1000, 8'h0, 0, r); chk("R6 later occurrence breaks", 32'(r), 32'(PRE1));
  endtask

  task automatic t_seq();
    logic [4:0]  r;
    logic [31:0] d;
    quiesce();
    wr(4'd1, 32'h100); wr(4'd0, 32'h1);
    wr(4'd4, 32'h200); wr(4'd3, 32'h1);
    wr(4'd9, 32'h1); wr(4'd8, 32'd0);
    issue(32'h200, 8'h0, 0, r); chk("R7 ch1 unarmed silent", 32'(r), 32'(NONE));
    issue(32'h100, 8'h0, 0, r); chk("R7 ch0 silent in linked mode", 32'(r), 32'(NONE));
    issue(32'h200, 8'h0, 0, r); chk("R7 ch1 breaks once armed", 32'(r), 32'(PRE1));
    wr(4'd8, 32'd0);
    issue(32'h200, 8'h0, 0, r); chk("R8 count write disarms", 32'(r), 32'(NONE));
    rd(4'd8, d); chk("R8 count reloaded", d, 32'd0);
    wr(4'd9, 32'h0);
    issue(32'h100, 8'h0, 0, r); chk("R7 independent ch0", 32'(r), 32'(PRE0));
    issue(32'h200, 8'h0, 0, r); chk("R7 independent ch1", 32'(r), 32'(PRE1));
  endtask

  task automatic t_status();
    logic [4:0]  r;
    logic [31:0] d;
    quiesce();
    rd(4'd10, d); chk("R9 status cleared", d, 32'h0);
    wr(4'd1, 32'h500); wr(4'd0, 32'h1);
    issue(32'h500, 8'h0, 0, r);
    wr(4'd0, 32'h0);
    rd(4'd10, d); chk("R9 status set by break", d, 32'h1);
    wr(4'd10, 32'h2);
    rd(4'd10, d); chk("R9 other-bit clear keeps status", d, 32'h1);
    wr(4'd10, 32'h1);
    rd(4'd10, d); chk("R9 write-one clears status", d, 32'h0);
  endtask

  task automatic t_prio();
    logic [4:0]  r;
    logic [31:0] d;
    quiesce();
    wr(4'd1, 32'h900); wr(4'd0, 32'h1); wr(4'd4, 32'h900); wr(4'd3, 32'h1);
    issue(32'h900, 8'h0, 0, r); chk("R10 lowest channel reported", 32'(r), 32'(PRE0));
    rd(4'd10, d); chk("R10 both status bits set", d, 32'h3);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_addr();
    t_post();
    t_asid();
    t_data();
    t_count();
    t_seq();
    t_status();
    t_prio();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule